// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the codec-side serializer of a time-slotted serial audio link. It runs on the bit clock and samples a frame-sync input. Each frame is 256 bits long. It begins with a 16-bit tag slot and continues with twelve 20-bit data slots, all sent on one serial output line. The tag carries a ready flag and one valid flag for each of the first four data slots. Those four slots carry payload words supplied by the surrounding logic. Every other bit of the frame is driven low.

The block polices frame spacing on its own. A sync rising edge that comes sooner than 256 bit clocks after the previous rising edge is not taken as a frame start. The frame in progress is abandoned and the line stays low. Transmission resumes only when a rising edge arrives at least 256 bit clocks after the last rising edge. The payload words and flags are copied into a shadow register at the moment a frame is accepted, so the producer may change them freely while the frame is on the wire.

Top module: `audio_link_tx`

## Requirements
- R1: After the synchronous active-high reset `rst`, `sdata_o` is 0, and the first sync rising edge that follows is accepted as a frame start.
- R2: A frame start is a rising edge of `sync_i`: the input is sampled low on one rising clock edge and high on the next. Holding `sync_i` high over further edges does not restart the frame.
- R3: The edge that samples an accepted rising edge is edge E. Frame bit 0 appears on `sdata_o` after edge E+1, and frame bit i appears after edge E+1+i, for i from 0 to 255.
- R4: Tag bit 15 (frame bit 0) equals the captured `ready_i`. Tag bits 14, 13, 12 and 11 (frame bits 1 to 4) equal the captured `valid_i[0]`, `valid_i[1]`, `valid_i[2]` and `valid_i[3]`. Tag bits 10 down to 0 (frame bits 5 to 15) are 0.
- R5: Data slot k, for k from 1 to 4, occupies frame bits 16+20(k-1) through 35+20(k-1). It carries `payload_i[20k-1:20k-20]` MSB first when `valid_i[k-1]` was set at capture.
- R6: A data slot whose captured valid flag is clear is sent as all zeros. Slots 5 to 12 (frame bits 96 to 255) are always 0.
- R7: `ready_i`, `valid_i` and `payload_i` are captured on the edge that accepts the frame. Changes to them after that edge do not affect the frame being sent.
- R8: A rising edge sampled exactly 256 edges after the previous accepted one is accepted. The new frame follows the old one with no gap.
- R9: A rising edge sampled less than 256 edges after the previous rising edge (accepted or rejected) is rejected. `sdata_o` is 0 from that edge on, until a rising edge at least 256 edges after the last rising edge is accepted.
- R10: When a frame has sent its 256 bits and no new rising edge came on time, `sdata_o` stays 0 until a later rising edge, which is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync; a rising edge marks a frame start |
| ready_i | input | 1 | Link-operational flag sent in tag bit 15 |
| valid_i | input | 4 | Valid flags for data slots 1 to 4 (bit 0 = slot 1) |
| payload_i | input | 80 | Payload words, slot 1 in bits 19:0, slot 4 in bits 79:60 |
| sdata_o | output | 1 | Registered serial frame output |

## Verification
The bench places rising edges exactly 256 edges apart, and also 255 edges apart, to confirm the spacing boundary. A design that is off by one either rejects a legal back-to-back frame or accepts one a clock early. It aborts frames part-way through. It then checks that the line stays low, and that a second early edge, timed from the rejected edge, is also turned away. A design that keeps sending or restarts at once would put data on the line. It also rewrites the payload and flags mid-frame, and holds sync high over several edges. A design without the shadow copy would mix old and new words, and one that reacts to level instead of edge would restart the frame.

// File: rtl/alt_pkg.sv
package alt_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_SEND  = 2'd1,
    ST_BLOCK = 2'd2
  } seq_state_e;

endpackage

// File: rtl/alt_sync_edge.sv
module alt_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic rise_o
);

  logic sync_q;

  // Reset to 1 so a sync held high through reset is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b1;
    else     sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/alt_frame_seq.sv
module alt_frame_seq
  import alt_pkg::*;
#(
  parameter int FRAME_W = 256,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             emit_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  seq_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             load;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    load  = 1'b0;
    case (st)
      ST_WAIT: begin
        if (rise_i) begin
          load  = 1'b1;
          st_n  = ST_SEND;
          cnt_n = '0;
        end
      end
      ST_SEND: begin
        if (rise_i) begin
          cnt_n = '0;
          if (cnt == LAST) load = 1'b1;
          else             st_n = ST_BLOCK;
        end else if (cnt == LAST) begin
          st_n  = ST_WAIT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_BLOCK: begin
        if (rise_i) begin
          cnt_n = '0;
          if (cnt == LAST) begin
            load = 1'b1;
            st_n = ST_SEND;
          end
        end else if (cnt == LAST) begin
          st_n  = ST_WAIT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        st_n  = ST_WAIT;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_WAIT;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign state_o = st;
  assign cnt_o   = cnt;
  assign load_o  = load;
  // An early edge silences the line on the very edge that samples it.
  assign emit_o  = (st == ST_SEND) && !(rise_i && (cnt != LAST));

  AST_EARLY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && rise_i && cnt != LAST) |=> (st == ST_BLOCK && cnt == '0)); // R9

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BLOCK && rise_i && cnt != LAST) |=> (st == ST_BLOCK)); // R9

  AST_END_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && !rise_i && cnt == LAST) |=> (st == ST_WAIT)); // R10

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && rise_i && cnt == LAST) |=> (st == ST_SEND && cnt == '0)); // R8

  AST_SEND_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && !rise_i && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/alt_slot_mux.sv
module alt_slot_mux #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int DATA_SLOTS = 4,
  parameter int CNT_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_i,
  input  logic                         ready_i,
  input  logic [DATA_SLOTS-1:0]        valid_i,
  input  logic [DATA_SLOTS*SLOT_W-1:0] payload_i,
  input  logic [CNT_W-1:0]             cnt_i,
  output logic                         bit_o
);

  logic                         sh_rdy;
  logic [DATA_SLOTS-1:0]        sh_vld;
  logic [DATA_SLOTS*SLOT_W-1:0] sh_pay;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_rdy <= 1'b0;
      sh_vld <= '0;
      sh_pay <= '0;
    end else if (load_i) begin
      sh_rdy <= ready_i;
      sh_vld <= valid_i;
      sh_pay <= payload_i;
    end
  end

  // Tag word: ready on top, slot flags below it, remaining bits zero.
  logic [TAG_W-1:0] tag_w;
  logic [TAG_W-1:0] tag_mask;
  logic             in_tag;

  always_comb begin
    tag_w = '0;
    tag_w[TAG_W-1] = sh_rdy;
    for (int k = 0; k < DATA_SLOTS; k++) tag_w[TAG_W-2-k] = sh_vld[k];
  end

  assign in_tag   = cnt_i < CNT_W'(TAG_W);
  assign tag_mask = TAG_W'(1) << (CNT_W'(TAG_W - 1) - cnt_i);

  logic [DATA_SLOTS-1:0] slot_bit;

  for (genvar k = 0; k < DATA_SLOTS; k++) begin : g_slot
    localparam int START = TAG_W + k * SLOT_W;
    logic [SLOT_W-1:0] word;
    logic [SLOT_W-1:0] mask;
    logic              hit;
    assign word = sh_pay[k*SLOT_W +: SLOT_W];
    assign hit  = (cnt_i >= CNT_W'(START)) && (cnt_i < CNT_W'(START + SLOT_W));
    assign mask = SLOT_W'(1) << (CNT_W'(START + SLOT_W - 1) - cnt_i);
    assign slot_bit[k] = hit && sh_vld[k] && (|(word & mask));
  end

  assign bit_o = in_tag ? (|(tag_w & tag_mask)) : (|slot_bit);

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(sh_pay) && $stable(sh_vld) && $stable(sh_rdy))); // R7

  AST_SHADOW_TAKE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (sh_pay == $past(payload_i) && sh_vld == $past(valid_i))); // R7

endmodule

// File: rtl/audio_link_tx.sv
module audio_link_tx
  import alt_pkg::*;
#(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int NUM_SLOTS  = 12,
  parameter int DATA_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_i,
  input  logic                         ready_i,
  input  logic [DATA_SLOTS-1:0]        valid_i,
  input  logic [DATA_SLOTS*SLOT_W-1:0] payload_i,
  output logic                         sdata_o
);

  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int DATA_END = TAG_W + DATA_SLOTS * SLOT_W;

  logic             rise;
  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             emit;
  logic             frame_bit;

  alt_sync_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  alt_frame_seq #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .state_o (st),
    .cnt_o   (cnt),
    .load_o  (load),
    .emit_o  (emit)
  );

  alt_slot_mux #(
    .TAG_W      (TAG_W),
    .SLOT_W     (SLOT_W),
    .DATA_SLOTS (DATA_SLOTS),
    .CNT_W      (CNT_W)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .ready_i   (ready_i),
    .valid_i   (valid_i),
    .payload_i (payload_i),
    .cnt_i     (cnt),
    .bit_o     (frame_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) sdata_o <= 1'b0;
    else     sdata_o <= emit & frame_bit;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SEND) |=> !sdata_o); // R10

  AST_TAG_RSVD: assert property (@(posedge clk) disable iff (rst)
    (emit && cnt > CNT_W'(DATA_SLOTS) && cnt < CNT_W'(TAG_W)) |=> !sdata_o); // R4

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && cnt >= CNT_W'(DATA_END)) |=> !sdata_o); // R6

endmodule

// File: tb/audio_link_tx_tb.sv
`timescale 1ns/1ps
module audio_link_tx_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        sync_i;
  logic        ready_i;
  logic [3:0]  valid_i;
  logic [79:0] payload_i;
  logic        sdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic        e_rdy;
  logic [3:0]  e_vld;
  logic [79:0] e_pay;

  always #2 clk = ~clk;

  audio_link_tx u_dut (
    .clk       (clk),
    .rst       (rst),
    .sync_i    (sync_i),
    .ready_i   (ready_i),
    .valid_i   (valid_i),
    .payload_i (payload_i),
    .sdata_o   (sdata_o)
  );

  function automatic logic exp_bit(input int i);
    int j, s, p;
    if (i == 0) return e_rdy;
    if (i < 5)  return e_vld[i-1];
    if (i < 16) return 1'b0;
    j = i - 16;
    s = j / 20;
    p = j % 20;
    if (s < 4 && e_vld[s]) return e_pay[s*20 + 19 - p];
    return 1'b0;
  endfunction

  function automatic string region(input int i);
    if (i < 5)  return "R4";
    if (i < 16) return "R4";
    if (i < 96) return "R5";
    return "R6";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic tick_check(input logic exp, input string req);
    @(negedge clk);
    n_chk++;
    if (sdata_o !== exp) begin
      n_err++;
      $display("FAIL %s t=%0t sdata_o actual=%b expected=%b", req, $time, sdata_o, exp);
    end
  endtask

  task automatic scramble();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    payload_i = r[79:0];
    ready_i   = r[80];
    valid_i   = r[84:81];
  endtask

  // Raise sync at the current negedge with new fields, then check nbits frame bits.
  task automatic frame_body(input logic rdy, input logic [3:0] vld,
                            input logic [79:0] pay, input int nbits, input string req0);
    ready_i = rdy; valid_i = vld; payload_i = pay; sync_i = 1'b1;
    e_rdy = rdy; e_vld = vld; e_pay = pay;
    tick_check(1'b0, req0);             // edge E: idle or last bit of previous frame
    for (int i = 0; i < nbits; i++) begin
      if (i == 3) sync_i = 1'b0;        // R2: sync held high over several edges
      if (i == 5) scramble();           // R7: inputs change mid-frame
      tick_check(exp_bit(i), (i == 0) ? "R3" : region(i));
    end
  endtask

  task automatic rand_frame(input int nbits, input string req0);
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    frame_body(r[80], r[84:81], r[79:0], nbits, req0);
  endtask

  initial begin
    #800000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; sync_i = 1'b0; ready_i = 1'b0; valid_i = '0; payload_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: line low after reset
    for (int i = 0; i < 3; i++) tick_check(1'b0, "R1");

    // R1, R4, R5: first frame after reset, all slots valid
    frame_body(1'b1, 4'b1111, {20'hF00F1, 20'h3C5A9, 20'h80001, 20'hA5A5A}, 255, "R1");
    tick_check(1'b0, "R6");
    for (int i = 0; i < 5; i++) tick_check(1'b0, "R10");

    // R6: partial validity, then nothing valid
    frame_body(1'b0, 4'b0101, {20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF}, 255, "R10");
    // R8: back-to-back, exactly 256 edges apart
    frame_body(1'b1, 4'b0000, {80{1'b1}}, 255, "R8");
    for (int f = 0; f < 6; f++) rand_frame(255, "R8");
    tick_check(1'b0, "R6");

    // R10: random late gaps before the next frame
    for (int f = 0; f < 3; f++) begin
      int gap;
      gap = 1 + int'($urandom_range(40));
      for (int g = 0; g < gap; g++) tick_check(1'b0, "R10");
      rand_frame(255, "R10");
      tick_check(1'b0, "R6");
    end

    // R9: early sync aborts a frame, spacing measured from the rejected edge
    for (int f = 0; f < 3; f++) begin
      int k;
      k = 10 + int'($urandom_range(190));
      rand_frame(k, "R9");
      sync_i = 1'b1;
      tick_check(1'b0, "R9");              // rejected edge R: line drops at once
      for (int t = 1; t <= 254; t++) begin
        if (t == 2) sync_i = 1'b0;
        if (t == 9) scramble();
        tick_check(1'b0, "R9");
      end
      if (f == 1) begin
        // one edge too early (R+255): rejected again
        sync_i = 1'b1;
        tick_check(1'b0, "R9");
        for (int t = 1; t <= 254; t++) begin
          if (t == 2) sync_i = 1'b0;
          tick_check(1'b0, "R9");
        end
      end
      tick_check(1'b0, "R9");              // reach negedge after R+255
      rand_frame(255, "R9");               // rise at R+256 is accepted
      tick_check(1'b0, "R6");
    end

    for (int i = 0; i < 4; i++) tick_check(1'b0, "R10");
    finish_run();
  end

endmodule